// File: doc/BRIEF.md
# Resonant Actuator Drive-Phase Sequencer

This block times the drive of a resonant actuator. It splits the drive signal into half-cycles. In each half-cycle the actuator is first driven with one polarity. The stored current is then removed. Next the output goes high-impedance and waits for the signal to settle. Last, the block watches a comparator that reports the sign of the back-EMF. When the back-EMF sign turns against the drive polarity, that moment marks the end of the half-period. The measured length becomes the new half-period estimate, the polarity flips and the next drive phase begins. Through this loop the estimate tracks the actuator's real resonance, starting from a programmed first guess.

All timing is counted in ticks of a 1 MHz clock-enable (`tick_en`), so one tick is 1 µs. The drive phase is shortened by the fixed sensing overhead, which makes a half-cycle that hits the expected crossing last exactly one estimate. A second mode is provided for non-resonant actuators. In that mode the drive-time code sets a fixed back-EMF sampling interval, polarity never changes and no tracking takes place. The analog stages, ADC conversion and amplitude control sit outside this block. It only drives the enables, the polarity, the sample window and the estimate.

Top module: `resdrv_seq`

## Requirements
- R1: After reset, and one clock after `stop`, the block is idle with `hiz_en`=1, `drive_en`=0, `adc_en`=0 and no further drive. `stop` wins over a simultaneous `start`. Reset sets `half_period` to 500 and `no_lock` to 0.
- R2: `start` without `stop` enters the drive phase on the next clock with `drive_pol`=1 (positive), `no_lock`=0 and `half_period` = 500 + 100 × `drv_code` ticks.
- R3: The phases of each half-cycle run in a fixed order:
  - Drive (`drive_en`=1) lasts max(estimate − dissipation − blanking − detect, 50) ticks.
  - Dissipation (`drive_en`=0, `hiz_en`=0) lasts 25 × (`diss_code`+1) ticks.
  - Blanking (`hiz_en`=1, `adc_en`=0) lasts 25 × (`blank_code`+1) ticks.
  - Watch (`hiz_en`=1, `adc_en`=1) follows.
- R4: During watch, a crossing is accepted on any tick from the detect-time-th watch tick onward, where the detect time is 100 × (`zcw_code`+1). A crossing is a tick where `bemf_pos` (1 = positive back-EMF) differs from `drive_pol`. On a crossing, `half_period` becomes the number of ticks since the half-cycle's drive began, `drive_pol` toggles and drive restarts on the next clock.
- R5: A measured half-period is clamped to the range 500 to 6000 ticks before it is stored.
- R6: If no crossing is seen by watch tick (detect time + estimate), the estimate is kept, polarity toggles, drive restarts and `no_lock` is set. `no_lock` stays set until the next `start`.
- R7: A crossing on the very tick the timeout expires counts as a crossing: the estimate is updated from the measurement.
- R8: With `mode_erm`=1, the drive phase lasts 500 + 100 × `drv_code` ticks with no overhead deducted. The watch lasts exactly the detect time. `bemf_pos` is ignored, `drive_pol` stays 1 and `half_period` is unchanged.
- R9: Phase and half-cycle timing advance only on clocks with `tick_en`=1. `start` and `stop` act on any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | 1 MHz time-base enable, one clock wide |
| start | input | 1 | Load initial estimate and begin driving |
| stop | input | 1 | Return to idle, output high-impedance |
| mode_erm | input | 1 | 1 = fixed-interval non-resonant mode |
| drv_code | input | 5 | Initial half-period / sampling interval code |
| diss_code | input | 4 | Current-dissipation time code |
| blank_code | input | 4 | Blanking time code |
| zcw_code | input | 2 | Minimum zero-crossing detect time code |
| bemf_pos | input | 1 | Comparator: back-EMF sign, 1 = positive |
| drive_en | output | 1 | Output stage driving |
| drive_pol | output | 1 | Drive polarity, 1 = positive |
| hiz_en | output | 1 | Output stage high-impedance |
| adc_en | output | 1 | Back-EMF sampling window |
| half_period | output | 14 | Current half-period estimate in ticks |
| no_lock | output | 1 | Sticky: a half-cycle ended by timeout |

## Verification
Two events can fall on the same tick: the crossing detector and the watch timeout. Each wants to end the half-cycle, but they differ in what happens to the estimate. The bench provokes this by flipping the comparator so that it is first sampled on exactly the final permitted watch tick, which is twice the current estimate after drive start. It then judges the result at the next drive edge: the half-cycle must last that long and the stored estimate must equal the measurement rather than the old value. A second coincidence, `start` and `stop` in the same clock, is driven and judged to leave the block idle.

// File: rtl/resdrv_pkg.sv
`timescale 1ns/1ps
package resdrv_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DRIVE,
    PH_DISS,
    PH_BLANK,
    PH_WATCH
  } phase_t;

  // Linear code-to-ticks map: base + code * step.
  function automatic int lin_ticks(input int code, input int base, input int step);
    return base + code * step;
  endfunction

  // Limit a measured length to the legal estimate range.
  function automatic int clamp_ticks(input int x, input int lo, input int hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

  // Drive phase = estimate minus sensing overhead, never below a floor.
  function automatic int drive_span(input int est, input int overhead, input int floor_t);
    if (est >= overhead + floor_t) return est - overhead;
    return floor_t;
  endfunction

endpackage

// File: rtl/resdrv_cnt.sv
`timescale 1ns/1ps
module resdrv_cnt #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/resdrv_track.sv
`timescale 1ns/1ps
module resdrv_track
  import resdrv_pkg::*;
#(
  parameter int HP_W   = 14,
  parameter int HP_MIN = 500,
  parameter int HP_MAX = 6000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [HP_W-1:0] load_val,
  input  logic            upd,
  input  logic [HP_W-1:0] meas,
  output logic [HP_W-1:0] est
);

  always_ff @(posedge clk) begin
    if (rst)       est <= HP_W'(HP_MIN);
    else if (load) est <= load_val;
    else if (upd)  est <= HP_W'(clamp_ticks(int'(meas), HP_MIN, HP_MAX));
  end

endmodule

// File: rtl/resdrv_fsm.sv
`timescale 1ns/1ps
module resdrv_fsm
  import resdrv_pkg::*;
#(
  parameter int HP_W = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            start,
  input  logic            stop,
  input  logic            erm,
  input  logic            cmp,
  input  logic [HP_W-1:0] ph_cnt,
  input  logic [HP_W-1:0] drv_len,
  input  logic [HP_W-1:0] diss_len,
  input  logic [HP_W-1:0] blank_len,
  input  logic [HP_W-1:0] zc_len,
  input  logic [HP_W-1:0] tmo_len,
  output phase_t          phase,
  output logic            pol,
  output logic            no_lock,
  output logic            ev_xing,
  output logic            ev_tmo,
  output logic            ph_clr,
  output logic            hc_clr
);

  phase_t nxt;
  logic   in_watch, zc_open, erm_done;

  always_comb begin
    in_watch = tick && (phase == PH_WATCH);
    zc_open  = ph_cnt >= (zc_len - HP_W'(1));
    ev_xing  = in_watch && !erm && zc_open && (cmp != pol);
    ev_tmo   = in_watch && !erm && !ev_xing && (ph_cnt == tmo_len - HP_W'(1));
    erm_done = in_watch && erm && (ph_cnt == zc_len - HP_W'(1));

    nxt = phase;
    case (phase)
      PH_IDLE:  nxt = PH_IDLE;
      PH_DRIVE: if (tick && ph_cnt == drv_len - HP_W'(1))   nxt = PH_DISS;
      PH_DISS:  if (tick && ph_cnt == diss_len - HP_W'(1))  nxt = PH_BLANK;
      PH_BLANK: if (tick && ph_cnt == blank_len - HP_W'(1)) nxt = PH_WATCH;
      PH_WATCH: if (ev_xing || ev_tmo || erm_done)          nxt = PH_DRIVE;
      default:  nxt = PH_IDLE;
    endcase
    if (start) nxt = PH_DRIVE;
    if (stop)  nxt = PH_IDLE;

    ph_clr = start || stop || (nxt != phase);
    hc_clr = start || stop || (phase == PH_IDLE) ||
             ((phase == PH_WATCH) && (nxt == PH_DRIVE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      pol     <= 1'b1;
      no_lock <= 1'b0;
    end else begin
      phase <= nxt;
      if (!stop) begin
        if (start) begin
          pol     <= 1'b1;
          no_lock <= 1'b0;
        end else begin
          if (ev_xing || ev_tmo) pol <= ~pol;
          if (ev_tmo) no_lock <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/resdrv_seq.sv
`timescale 1ns/1ps
module resdrv_seq
  import resdrv_pkg::*;
#(
  parameter int HP_W        = 14,
  parameter int DT_W        = 5,
  parameter int DS_W        = 4,
  parameter int BL_W        = 4,
  parameter int ZC_W        = 2,
  parameter int DRV_BASE    = 500,
  parameter int DRV_STEP    = 100,
  parameter int SETTLE_STEP = 25,
  parameter int ZC_STEP     = 100,
  parameter int HP_MIN      = 500,
  parameter int HP_MAX      = 6000,
  parameter int MIN_DRIVE   = 50
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_en,
  input  logic            start,
  input  logic            stop,
  input  logic            mode_erm,
  input  logic [DT_W-1:0] drv_code,
  input  logic [DS_W-1:0] diss_code,
  input  logic [BL_W-1:0] blank_code,
  input  logic [ZC_W-1:0] zcw_code,
  input  logic            bemf_pos,
  output logic            drive_en,
  output logic            drive_pol,
  output logic            hiz_en,
  output logic            adc_en,
  output logic [HP_W-1:0] half_period,
  output logic            no_lock
);

  localparam int NCNT = 2;  // 0: phase counter, 1: half-cycle counter

  phase_t          phase;
  logic [HP_W-1:0] est, init_est, drv_len, diss_len, blank_len, zc_len, tmo_len;
  logic [HP_W-1:0] ph_cnt, hc_cnt, meas;
  logic [HP_W-1:0] cnt_val [NCNT];
  logic [NCNT-1:0] cnt_clr;
  logic            ph_clr, hc_clr, ev_xing, ev_tmo;

  always_comb begin
    init_est  = HP_W'(lin_ticks(int'(drv_code), DRV_BASE, DRV_STEP));
    diss_len  = HP_W'(lin_ticks(int'(diss_code), SETTLE_STEP, SETTLE_STEP));
    blank_len = HP_W'(lin_ticks(int'(blank_code), SETTLE_STEP, SETTLE_STEP));
    zc_len    = HP_W'(lin_ticks(int'(zcw_code), ZC_STEP, ZC_STEP));
    drv_len   = mode_erm ? est :
                HP_W'(drive_span(int'(est),
                                 int'(diss_len) + int'(blank_len) + int'(zc_len),
                                 MIN_DRIVE));
    tmo_len   = zc_len + est;
  end

  assign cnt_clr = {hc_clr, ph_clr};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    resdrv_cnt #(.W(HP_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .tick (tick_en),
      .clr  (cnt_clr[g]),
      .cnt  (cnt_val[g])
    );
  end

  assign ph_cnt = cnt_val[0];
  assign hc_cnt = cnt_val[1];
  assign meas   = hc_cnt + HP_W'(1);

  resdrv_fsm #(.HP_W(HP_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_en),
    .start     (start),
    .stop      (stop),
    .erm       (mode_erm),
    .cmp       (bemf_pos),
    .ph_cnt    (ph_cnt),
    .drv_len   (drv_len),
    .diss_len  (diss_len),
    .blank_len (blank_len),
    .zc_len    (zc_len),
    .tmo_len   (tmo_len),
    .phase     (phase),
    .pol       (drive_pol),
    .no_lock   (no_lock),
    .ev_xing   (ev_xing),
    .ev_tmo    (ev_tmo),
    .ph_clr    (ph_clr),
    .hc_clr    (hc_clr)
  );

  resdrv_track #(.HP_W(HP_W), .HP_MIN(HP_MIN), .HP_MAX(HP_MAX)) u_track (
    .clk      (clk),
    .rst      (rst),
    .load     (start && !stop),
    .load_val (init_est),
    .upd      (ev_xing && !start && !stop),
    .meas     (meas),
    .est      (est)
  );

  assign drive_en    = (phase == PH_DRIVE);
  assign hiz_en      = (phase == PH_IDLE) || (phase == PH_BLANK) || (phase == PH_WATCH);
  assign adc_en      = (phase == PH_WATCH);
  assign half_period = est;

endmodule

// File: rtl/resdrv_seq_chk.sv
`timescale 1ns/1ps
module resdrv_seq_chk #(
  parameter int HP_W     = 14,
  parameter int DT_W     = 5,
  parameter int DRV_BASE = 500,
  parameter int DRV_STEP = 100,
  parameter int HP_MIN   = 500,
  parameter int HP_MAX   = 6000
) (
  input logic            clk,
  input logic            rst,
  input logic            tick_en,
  input logic            start,
  input logic            stop,
  input logic            mode_erm,
  input logic [DT_W-1:0] drv_code,
  input logic            drive_en,
  input logic            drive_pol,
  input logic            hiz_en,
  input logic            adc_en,
  input logic [HP_W-1:0] half_period,
  input logic            no_lock,
  input logic            ev_xing,
  input logic            ev_tmo
);

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    stop |=> (hiz_en && !drive_en && !adc_en)); // R1

  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    (start && !stop) |=> (drive_en && drive_pol && !no_lock &&
      (int'(half_period) == DRV_BASE + DRV_STEP * int'($past(drv_code))))); // R2

  AST_DRIVE_TO_DISS: assert property (@(posedge clk) disable iff (rst)
    (drive_en && !start && !stop) |=> (drive_en || !hiz_en)); // R3

  AST_WATCH_AFTER_BLANK: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_en) |-> ($past(hiz_en) && !$past(drive_en))); // R3

  AST_XING_FLIP: assert property (@(posedge clk) disable iff (rst)
    (ev_xing && !start && !stop) |=> (drive_pol != $past(drive_pol))); // R4

  AST_HP_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(half_period) >= HP_MIN) && (int'(half_period) <= HP_MAX)); // R5

  AST_TMO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ev_tmo && !start && !stop) |=>
      (no_lock && $stable(half_period) && (drive_pol != $past(drive_pol)))); // R6

  AST_NOLOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (no_lock && !start) |=> no_lock); // R6

  AST_XING_OVER_TMO: assert property (@(posedge clk) disable iff (rst)
    !(ev_xing && ev_tmo)); // R7

  AST_ERM_NO_TRACK: assert property (@(posedge clk) disable iff (rst)
    (mode_erm && !start && !stop) |=> ($stable(half_period) && $stable(drive_pol))); // R8

  AST_NOTICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !start && !stop) |=>
      $stable({drive_en, hiz_en, adc_en, drive_pol, half_period})); // R9

endmodule

bind resdrv_seq resdrv_seq_chk #(
  .HP_W(HP_W), .DT_W(DT_W), .DRV_BASE(DRV_BASE), .DRV_STEP(DRV_STEP),
  .HP_MIN(HP_MIN), .HP_MAX(HP_MAX)
) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .start(start), .stop(stop),
  .mode_erm(mode_erm), .drv_code(drv_code), .drive_en(drive_en),
  .drive_pol(drive_pol), .hiz_en(hiz_en), .adc_en(adc_en),
  .half_period(half_period), .no_lock(no_lock), .ev_xing(ev_xing), .ev_tmo(ev_tmo)
);

// File: tb/resdrv_seq_tb.sv
`timescale 1ns/1ps
module resdrv_seq_tb;

  logic        clk = 1'b0, rst = 1'b1, tick_en = 1'b1, start = 1'b0, stop = 1'b0;
  logic        mode_erm = 1'b0, bemf_pos = 1'b1;
  logic [4:0]  drv_code = 5'd5;
  logic [3:0]  diss_code = 4'd3, blank_code = 4'd1;
  logic [1:0]  zcw_code = 2'd0;
  logic        drive_en, drive_pol, hiz_en, adc_en, no_lock;
  logic [13:0] half_period;

  resdrv_seq u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .start(start), .stop(stop),
    .mode_erm(mode_erm), .drv_code(drv_code), .diss_code(diss_code),
    .blank_code(blank_code), .zcw_code(zcw_code), .bemf_pos(bemf_pos),
    .drive_en(drive_en), .drive_pol(drive_pol), .hiz_en(hiz_en), .adc_en(adc_en),
    .half_period(half_period), .no_lock(no_lock)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Scoreboard: one expected item per half-cycle, judged at the next drive edge.
  typedef struct {int len; int est; bit pol; bit nl; string tag;} item_t;
  item_t q[$];
  bit    armed = 0;
  bit    de_prev = 0;
  int    cyc = 0, last_rise = 0;
  int    m_est, m_pol, m_nl;

  always @(negedge clk) begin
    cyc++;
    if (drive_en && !de_prev) begin
      if (armed && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(cyc - last_rise == it.len, {it.tag, " length"}, cyc - last_rise, it.len);
        chk(int'(half_period) == it.est, {it.tag, " estimate"}, half_period, it.est);
        chk(drive_pol == it.pol, {it.tag, " polarity"}, drive_pol, it.pol);
        chk(no_lock == it.nl, {it.tag, " no_lock"}, no_lock, it.nl);
      end
      armed = 1;
      last_rise = cyc;
    end
    de_prev = drive_en;
  end

  function automatic int lim(input int x);
    return (x < 500) ? 500 : ((x > 6000) ? 6000 : x);
  endfunction

  task automatic do_start();
    q.delete();
    armed = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    m_est = 500 + 100 * int'(drv_code);
    m_pol = 1;
    m_nl  = 0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  // Called at the first negedge of a half-cycle; returns at the first of the next.
  task automatic hc(input int m, input bit xing, input string tag);
    item_t it;
    bemf_pos = drive_pol;
    if (xing) begin
      it.len = m;
      it.est = lim(m);
    end else begin
      it.len = 2 * m_est;
      it.est = m_est;
      m_nl   = 1;
    end
    m_pol  = 1 - m_pol;
    it.pol = m_pol[0];
    it.nl  = m_nl[0];
    it.tag = tag;
    m_est  = it.est;
    q.push_back(it);
    if (xing) begin
      repeat (m - 1) @(negedge clk);
      bemf_pos = ~bemf_pos;
      @(negedge clk);
    end else begin
      repeat (it.len) @(negedge clk);
    end
  endtask

  // Measures drive, dissipation and blanking lengths; returns at first watch negedge.
  task automatic phases(input int ed, input int edi, input int eb, input string tag);
    int c;
    c = 0;
    while (drive_en) begin c++; @(negedge clk); end
    chk(c == ed, {tag, " drive length"}, c, ed);
    c = 0;
    while (!drive_en && !hiz_en) begin c++; @(negedge clk); end
    chk(c == edi, {tag, " dissipation length"}, c, edi);
    c = 0;
    while (hiz_en && !adc_en) begin c++; @(negedge clk); end
    chk(c == eb, {tag, " blanking length"}, c, eb);
    chk(adc_en && hiz_en, {tag, " watch entered"}, adc_en, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(hiz_en && !drive_en && !adc_en, "R1 reset outputs", {hiz_en, drive_en, adc_en}, 3'b100);
    chk(half_period == 14'd500 && !no_lock, "R1 reset estimate", half_period, 500);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R2 / R3: start and phase order with drive 1000, diss 100, blank 50, detect 100
    do_start();
    chk(drive_en && drive_pol, "R2 start drive", {drive_en, drive_pol}, 2'b11);
    chk(half_period == 14'd1000, "R2 initial estimate", half_period, 1000);
    phases(750, 100, 50, "R3");
    do_stop();
    chk(hiz_en && !drive_en && !adc_en, "R1 stop idle", {hiz_en, drive_en, adc_en}, 3'b100);
    repeat (300) @(negedge clk);
    chk(hiz_en && !drive_en, "R1 stays idle", drive_en, 0);

    // R4 tracking, R6 timeout and stickiness, R7 crossing on last tick
    do_start();
    hc(1000, 1, "R4");
    hc(1200, 1, "R4");
    hc(1300, 1, "R4");
    hc(0, 0, "R6");
    hc(1400, 1, "R6");
    hc(2800, 1, "R7");

    // R1: start and stop together
    @(negedge clk) begin start = 1'b1; stop = 1'b1; end
    @(negedge clk) begin start = 1'b0; stop = 1'b0; end
    chk(hiz_en && !drive_en && !adc_en, "R1 stop over start", drive_en, 0);
    repeat (100) @(negedge clk);
    chk(!drive_en, "R1 no drive after stop", drive_en, 0);

    // R5 upper clamp; R2 start clears no_lock
    drv_code = 5'd31;
    do_start();
    chk(!no_lock, "R2 start clears no_lock", no_lock, 0);
    chk(half_period == 14'd3600, "R2 max code estimate", half_period, 3600);
    hc(6500, 1, "R5");
    hc(6000, 1, "R5");
    do_stop();

    // R3: drive floor when overhead exceeds estimate
    drv_code = 5'd0; diss_code = 4'd15; blank_code = 4'd15; zcw_code = 2'd3;
    bemf_pos = 1'b1;
    do_start();
    phases(50, 400, 400, "R3 floor");
    do_stop();

    // R8: fixed-interval mode ignores the comparator
    mode_erm = 1'b1;
    drv_code = 5'd2; diss_code = 4'd3; blank_code = 4'd1; zcw_code = 2'd0;
    bemf_pos = 1'b1;
    do_start();
    chk(half_period == 14'd700 && drive_pol, "R8 interval load", half_period, 700);
    phases(700, 100, 50, "R8");
    bemf_pos = 1'b0;
    begin
      int c;
      c = 0;
      while (adc_en) begin c++; @(negedge clk); end
      chk(c == 100, "R8 watch length", c, 100);
    end
    chk(drive_en && drive_pol, "R8 polarity held", drive_pol, 1);
    chk(half_period == 14'd700 && !no_lock, "R8 estimate held", half_period, 700);
    do_stop();
    mode_erm = 1'b0;
    bemf_pos = 1'b1;

    // R9: no progress without ticks
    drv_code = 5'd5;
    tick_en = 1'b0;
    do_start();
    repeat (2000) @(negedge clk);
    chk(drive_en && !hiz_en, "R9 frozen without tick", drive_en, 1);
    tick_en = 1'b1;
    phases(750, 100, 50, "R9");
    do_stop();

    finish_run();
  end

endmodule